// File: doc/BRIEF.md
# Multiplexer-Tree Logic Cell with Selectable Storage

This block is a single programmable logic element. Eight logic inputs feed a tree of three 2:1 multiplexers: an A-side mux (data `a0`/`a1`, select `sa`), a B-side mux (data `b0`/`b1`, select `sb`) and a final mux whose select is the OR of `s0` and `s1`. Each input can be tied to a constant, to a signal or to a signal's complement. That lets one cell form 2-, 3- and 4-input AND, NAND, OR and NOR gates, AND-OR and OR-AND terms, and exclusive-OR functions.

A static two-bit mode word picks how the combinational result reaches the output. It can go straight through (bypass), through a rising-edge D flip-flop, or through a latch that is transparent while the clock/gate input is high. The two storage elements share an active-low asynchronous clear. The mode word is treated as an enumerated state: `MODE_BYPASS` (00), `MODE_FLOP` (01), `MODE_LATCH` (10) and `MODE_RSVD` (11, behaves as bypass). The mode changes only when the configuration changes. There are no transitions driven by data: the output process decodes the current state.

Top module: `mux_logic_cell`

## Requirements
- R1: The combinational result is `(sa ? a1 : a0)` when both `s0` and `s1` are 0, and `(sb ? b1 : b0)` when either of them is 1.
- R2: With inputs tied to constants or to true or complemented signals, the cell realises 2-, 3- and 4-input AND and NAND over all input combinations.
- R3: With such tie-offs, the cell realises 2-, 3- and 4-input OR and NOR over all input combinations.
- R4: With such tie-offs, the cell realises an AND-OR term `(x1&x2)|x3|x4`, an OR-AND term `(x1|x2)&(x3|x4)`, and 2- and 3-input exclusive-OR.
- R5: In mode 00 (bypass) and mode 11 (reserved), `y` equals the combinational result at all times, with no clock edge needed.
- R6: In mode 01, `y` takes the combinational result sampled at each rising edge of `clk` and holds it between edges.
- R7: In mode 10, `y` follows the combinational result while `clk` is 1 and holds the last value while `clk` is 0.
- R8: While `rst_n` is 0, the stored value is 0 in modes 01 and 10 without any clock edge. In bypass, `rst_n` has no effect on `y`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Flip-flop clock and latch gate |
| rst_n | input | 1 | Active-low asynchronous clear of the storage |
| a0 | input | 1 | A-side data, chosen when `sa` = 0 |
| a1 | input | 1 | A-side data, chosen when `sa` = 1 |
| sa | input | 1 | A-side select |
| b0 | input | 1 | B-side data, chosen when `sb` = 0 |
| b1 | input | 1 | B-side data, chosen when `sb` = 1 |
| sb | input | 1 | B-side select |
| s0 | input | 1 | Final select term, ORed with `s1` |
| s1 | input | 1 | Final select term, ORed with `s0` |
| mode | input | 2 | Output mode: 00 bypass, 01 flip-flop, 10 latch, 11 bypass |
| y | output | 1 | Cell output |

## Verification
Sixteen gate mappings are each applied with all sixteen values of their four variables, and every result is compared with the plain Boolean expression of that gate. This separates a wrong A/B select, a wrong data leg and a final select built as AND instead of OR. Direct select patterns check each mux leg on its own. Timed sequences in flip-flop and latch mode change the data in the opposite clock phase, which tells edge capture apart from transparency and holding. Clear pulses between edges show that clearing needs no clock and that the bypass path ignores it.

// File: rtl/mlc_pkg.sv
package mlc_pkg;
    localparam int MODE_W = 2;

    typedef enum logic [MODE_W-1:0] {
        MODE_BYPASS = 2'b00,
        MODE_FLOP   = 2'b01,
        MODE_LATCH  = 2'b10,
        MODE_RSVD   = 2'b11
    } mode_e;
endpackage

// File: rtl/mlc_mux2.sv
module mlc_mux2 #(
    parameter int W = 1
) (
    input  logic [W-1:0] in0,
    input  logic [W-1:0] in1,
    input  logic         sel,
    output logic [W-1:0] out
);
    always_comb begin
        out = sel ? in1 : in0;
    end
endmodule

// File: rtl/mlc_mux_tree.sv
module mlc_mux_tree (
    input  logic clk,
    input  logic rst_n,
    input  logic a0,
    input  logic a1,
    input  logic sa,
    input  logic b0,
    input  logic b1,
    input  logic sb,
    input  logic s0,
    input  logic s1,
    output logic f
);
    localparam int LEGS = 2;

    logic [LEGS-1:0] leg_d0;
    logic [LEGS-1:0] leg_d1;
    logic [LEGS-1:0] leg_sel;
    logic [LEGS-1:0] leg_out;
    logic            final_sel;

    assign leg_d0  = {b0, a0};
    assign leg_d1  = {b1, a1};
    assign leg_sel = {sb, sa};

    for (genvar g = 0; g < LEGS; g++) begin : g_leg
        mlc_mux2 #(.W(1)) u_leg (
            .in0 (leg_d0[g]),
            .in1 (leg_d1[g]),
            .sel (leg_sel[g]),
            .out (leg_out[g])
        );
    end

    assign final_sel = s0 | s1;

    mlc_mux2 #(.W(1)) u_final (
        .in0 (leg_out[0]),
        .in1 (leg_out[1]),
        .sel (final_sel),
        .out (f)
    );

    // R1: with both final select terms low the A-side data reaches f
    p_a_path_r1: assert property (@(negedge clk) disable iff (!rst_n)
        (!s0 && !s1) |-> (f == (sa ? a1 : a0)));

    // R1: either final select term high routes the B-side data
    p_b_path_r1: assert property (@(negedge clk) disable iff (!rst_n)
        (s0 || s1) |-> (f == (sb ? b1 : b0)));
endmodule

// File: rtl/mlc_store.sv
module mlc_store
    import mlc_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  d,
    input  mode_e mode,
    output logic  y
);
    logic q_ff;
    logic q_lat;

    // state register: edge-triggered element
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_ff <= 1'b0;
        end else begin
            q_ff <= d;
        end
    end

    // level-sensitive element, open while clk is high
    always_latch begin
        if (!rst_n) begin
            q_lat <= 1'b0;
        end else if (clk) begin
            q_lat <= d;
        end
    end

    // output process: decode the configured mode
    always_comb begin
        unique case (mode)
            MODE_FLOP:   y = q_ff;
            MODE_LATCH:  y = q_lat;
            MODE_BYPASS: y = d;
            MODE_RSVD:   y = d;
            default:     y = d;
        endcase
    end

    // R7: at the end of the high phase the latch holds the current data
    p_latch_follow_r7: assert property (@(negedge clk) disable iff (!rst_n)
        q_lat == d);

    // R8: leaving clear, both storage elements still hold 0
    p_clr_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!q_ff && !q_lat));
endmodule

// File: rtl/mux_logic_cell.sv
module mux_logic_cell
    import mlc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       a0,
    input  logic       a1,
    input  logic       sa,
    input  logic       b0,
    input  logic       b1,
    input  logic       sb,
    input  logic       s0,
    input  logic       s1,
    input  logic [1:0] mode,
    output logic       y
);
    logic  f;
    mode_e mode_q;

    assign mode_q = mode_e'(mode);

    mlc_mux_tree u_tree (
        .clk   (clk),
        .rst_n (rst_n),
        .a0    (a0),
        .a1    (a1),
        .sa    (sa),
        .b0    (b0),
        .b1    (b1),
        .sb    (sb),
        .s0    (s0),
        .s1    (s1),
        .f     (f)
    );

    mlc_store u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (f),
        .mode  (mode_q),
        .y     (y)
    );

    // R5: bypass and reserved codes pass the tree result straight out
    p_bypass_r5: assert property (@(negedge clk) disable iff (!rst_n)
        ((mode == 2'b00) || (mode == 2'b11)) |-> (y == f));

    // R6: in flip-flop mode the output is the result sampled one edge earlier
    p_flop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b01) |=> ((mode != 2'b01) || (y == $past(f))));
endmodule

// File: tb/mux_logic_cell_tb.sv
`timescale 1ns/1ps
module mux_logic_cell_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       a0 = 0, a1 = 0, sa = 0, b0 = 0, b1 = 0, sb = 0, s0 = 0, s1 = 0;
    logic [1:0] mode = 2'b01;
    logic       y;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    typedef struct {
        logic  exp;
        string tag;
        string what;
    } item_t;

    item_t sb_q[$];
    event  chk_ev;

    always #2 clk = ~clk;

    mux_logic_cell u_dut (
        .clk(clk), .rst_n(rst_n),
        .a0(a0), .a1(a1), .sa(sa), .b0(b0), .b1(b1), .sb(sb),
        .s0(s0), .s1(s1), .mode(mode), .y(y)
    );

    // monitor: pop expected items and compare with the output
    initial begin
        forever begin
            @(chk_ev);
            while (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                n_chk++;
                if (y !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s %s: y=%b expected=%b", it.tag, it.what, y, it.exp);
                end
            end
        end
    end

    task automatic expect_y(input logic e, input string tag, input string what);
        item_t it;
        it.exp = e; it.tag = tag; it.what = what;
        sb_q.push_back(it);
        ->chk_ev;
        #0.1;
    endtask

    // tie order {a0,a1,sa,b0,b1,sb,s0,s1}
    task automatic drive(input logic [7:0] t);
        {a0, a1, sa, b0, b1, sb, s0, s1} = t;
    endtask

    function automatic logic [8:0] gate_map(input int g, input logic [3:0] v);
        logic x1, x2, x3, x4;
        logic ta0, ta1, tsa, tb0, tb1, tsb, ts0, ts1, e;
        x1 = v[0]; x2 = v[1]; x3 = v[2]; x4 = v[3];
        {ta0, ta1, tsa, tb0, tb1, tsb, ts0, ts1} = 8'h00;
        e = 1'b0;
        case (g)
            0:  begin ta1 = x1; tsa = x2; e = x1 & x2; end
            1:  begin ta1 = x1; tsa = x2; ts0 = ~x3; e = x1 & x2 & x3; end
            2:  begin ta1 = x1; tsa = x2; ts0 = ~x3; ts1 = ~x4; e = x1 & x2 & x3 & x4; end
            3:  begin ta0 = 1; ta1 = ~x1; tsa = x2; tb0 = 1; tb1 = 1; e = ~(x1 & x2); end
            4:  begin ta0 = 1; ta1 = ~x1; tsa = x2; tb0 = 1; tb1 = 1; ts0 = ~x3; e = ~(x1 & x2 & x3); end
            5:  begin ta0 = 1; ta1 = ~x1; tsa = x2; tb0 = 1; tb1 = 1; ts0 = ~x3; ts1 = ~x4;
                      e = ~(x1 & x2 & x3 & x4); end
            6:  begin ta0 = x1; ta1 = 1; tsa = x2; tb0 = 1; tb1 = 1; e = x1 | x2; end
            7:  begin ta0 = x1; ta1 = 1; tsa = x2; tb0 = 1; tb1 = 1; ts0 = x3; e = x1 | x2 | x3; end
            8:  begin ta0 = x1; ta1 = 1; tsa = x2; tb0 = 1; tb1 = 1; ts0 = x3; ts1 = x4;
                      e = x1 | x2 | x3 | x4; end
            9:  begin ta0 = ~x1; tsa = x2; e = ~(x1 | x2); end
            10: begin ta0 = ~x1; tsa = x2; ts0 = x3; e = ~(x1 | x2 | x3); end
            11: begin ta0 = ~x1; tsa = x2; ts0 = x3; ts1 = x4; e = ~(x1 | x2 | x3 | x4); end
            12: begin ta1 = x1; tsa = x2; tb0 = 1; tb1 = 1; ts0 = x3; ts1 = x4;
                      e = (x1 & x2) | x3 | x4; end
            13: begin tb0 = x1; tb1 = 1; tsb = x2; ts0 = x3; ts1 = x4; e = (x1 | x2) & (x3 | x4); end
            14: begin ta0 = x1; ta1 = ~x1; tsa = x2; e = x1 ^ x2; end
            default: begin ta0 = x1; ta1 = ~x1; tsa = x2; tb0 = ~x1; tb1 = x1; tsb = x2; ts0 = x3;
                      e = x1 ^ x2 ^ x3; end
        endcase
        return {ta0, ta1, tsa, tb0, tb1, tsb, ts0, ts1, e};
    endfunction

    function automatic string gate_tag(input int g);
        if (g < 6) return "R2";
        if (g < 12) return "R3";
        return "R4";
    endfunction

    initial begin
        #200000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run hung, finished=0 expected=1");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [8:0] m;
        // reset state, R8: clear forces 0 with no clock edge needed
        drive(8'b1000_0000);
        #1;
        expect_y(1'b0, "R8", "flop mode under clear");
        mode = 2'b10;
        #0.5;
        expect_y(1'b0, "R8", "latch mode under clear");
        mode = 2'b00;
        #0.3;
        expect_y(1'b1, "R8", "bypass ignores clear");
        @(negedge clk); #1;
        rst_n = 1'b1;

        // R1: individual legs of the tree
        @(negedge clk); drive(8'b1000_0000); #1; expect_y(1'b1, "R1", "A leg sa=0");
        @(negedge clk); drive(8'b1000_0001); #1; expect_y(1'b0, "R1", "B leg via s1");
        @(negedge clk); drive(8'b0000_1110); #1; expect_y(1'b1, "R1", "B leg sb=1 via s0");
        @(negedge clk); drive(8'b1010_0000); #1; expect_y(1'b0, "R1", "A leg sa=1");
        @(negedge clk); drive(8'b0001_0011); #1; expect_y(1'b1, "R1", "B leg both selects");

        // R2..R4: every gate mapping, all input values, bypass mode
        for (int g = 0; g < 16; g++) begin
            for (int v = 0; v < 16; v++) begin
                @(negedge clk);
                m = gate_map(g, 4'(v));
                drive(m[8:1]);
                #1;
                expect_y(m[0], gate_tag(g), $sformatf("gate %0d inputs %b", g, 4'(v)));
            end
        end

        // R5: reserved code acts as bypass, change seen between edges
        mode = 2'b11;
        for (int v = 0; v < 8; v++) begin
            @(posedge clk); #0.5;
            m = gate_map(15, 4'(v));
            drive(m[8:1]);
            #0.3;
            expect_y(m[0], "R5", $sformatf("reserved mode xor3 %b", 3'(v)));
        end

        // R6: flip-flop captures at rising edge and holds
        @(negedge clk); mode = 2'b01; drive(8'b1000_0000);
        @(posedge clk); #1; expect_y(1'b1, "R6", "capture 1 at edge");
        @(negedge clk); drive(8'b0000_0000); #0.5;
        expect_y(1'b1, "R6", "hold between edges");
        @(posedge clk); #1; expect_y(1'b0, "R6", "capture 0 at edge");
        @(negedge clk); drive(8'b0110_0000); #0.5;
        expect_y(1'b0, "R6", "hold before edge");
        @(posedge clk); #1; expect_y(1'b1, "R6", "capture a1 leg");

        // R8: asynchronous clear in flip-flop mode, mid low phase
        @(negedge clk); #0.5;
        rst_n = 1'b0; #0.3;
        expect_y(1'b0, "R8", "flop cleared without edge");
        mode = 2'b00; drive(8'b0000_0000);
        #0.3; rst_n = 1'b1;

        // R7: latch transparent while clk high, holds while low
        @(negedge clk); mode = 2'b10;
        @(posedge clk); #0.5; drive(8'b1000_0000); #0.3;
        expect_y(1'b1, "R7", "transparent while high");
        drive(8'b0000_0000); #0.3;
        expect_y(1'b0, "R7", "follows again while high");
        drive(8'b1000_0000);
        @(negedge clk); #0.5; drive(8'b0000_0000); #0.3;
        expect_y(1'b1, "R7", "holds while low");
        @(posedge clk); #0.5;
        expect_y(1'b0, "R7", "opens on high phase");

        // R8: clear while latch holds 1 in the low phase
        drive(8'b1000_0000);
        @(negedge clk); #0.5;
        expect_y(1'b1, "R7", "held 1 before clear");
        rst_n = 1'b0; #0.3;
        expect_y(1'b0, "R8", "latch cleared without edge");
        #0.3; rst_n = 1'b1; #0.3;
        expect_y(1'b0, "R8", "latch keeps 0 after clear in low phase");

        // R8: bypass output not affected by clear
        mode = 2'b00; drive(8'b1000_0000);
        @(negedge clk); #0.5; rst_n = 1'b0; #0.3;
        expect_y(1'b1, "R8", "bypass unaffected by clear");
        #0.3; rst_n = 1'b1;

        @(negedge clk);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule